// File: doc/BRIEF.md
# Seat Belt Reminder Controller

This controller watches a vehicle's ignition switch and a seat belt latch switch. When the ignition comes on, it starts a grace interval. If the belt is still open when that interval ends, it drives an alarm enable for a limited time. The alarm stops at the first of three events: its time runs out, the belt is latched, or the ignition goes off.

Time is measured in whole seconds. An external tick generator supplies a one-cycle strobe once per second. Both switch inputs arrive already debounced and synchronous to the clock. The alarm output feeds a tone generator that lives outside this block. A two-bit state code is also brought out so that the controller's position can be observed while debugging.

Top module: `belt_alarm_ctrl`

## Requirements
- R1: A synchronous active-high reset puts the controller in the idle state. In that state `stateOut` reads 0 and `alarmOut` is low.
- R2: In the idle state, a rising edge of `ignOn` moves the controller to the waiting state (`stateOut` = 1) at the next clock edge. A high level of `ignOn` that is already present at the first edge after reset also counts as a rising edge.
- R3: The controller may stay in the waiting state with `ignOn` high and `beltOn` low until WAIT_SECS ticks have been counted there. It then enters the alarm state (`stateOut` = 2, `alarmOut` high) on the clock edge that samples the WAIT_SECS-th tick.
- R4: In the waiting state, `beltOn` high or `ignOn` low returns the controller to idle at the next edge, and the alarm is never raised.
- R5: With no cancel condition present, the alarm state lasts until the ALARM_SECS-th tick counted there. The controller returns to idle on the edge that samples that tick.
- R6: `beltOn` high during the alarm state returns the controller to idle and lowers `alarmOut` at the next edge.
- R7: `ignOn` low during the alarm state returns the controller to idle and lowers `alarmOut` at the next edge.
- R8: After any return to idle, including an alarm timeout, the controller stays idle while `ignOn` remains high. It arms again only after `ignOn` goes low and then high.
- R9: If a cancel condition (`beltOn` high or `ignOn` low) and an expiring tick arrive in the same cycle, the cancel wins and the next state is idle.
- R10: The tick count starts from zero on every entry into a state. Ticks seen while idle, or in an earlier visit to a state, never shorten an interval.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ignOn | input | 1 | Ignition switch level, 1 = on |
| beltOn | input | 1 | Seat belt latch level, 1 = fastened |
| secTick | input | 1 | One-cycle strobe, once per second |
| alarmOut | output | 1 | Alarm enable |
| stateOut | output | 2 | State code: 0 idle, 1 waiting, 2 alarm |

## Verification
The bench aims at the edges of each interval:
- It checks the ninth tick against the tenth in the wait, and the fourth tick against the fifth in the alarm. An off-by-one counter would raise or drop the alarm one second early or late.
- It places a cancel on the same cycle as the expiring tick. A design that checks expiry first would sound the alarm for a belt that was already fastened.
- It keeps the ignition high after a timeout. A level-triggered arm would restart the wait and nag forever.
- It feeds ticks while idle and cancels part-way through a wait. A counter that is not cleared on state entry would shorten the next interval.

// File: rtl/belt_pkg.sv
package belt_pkg;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_WAIT  = 2'd1,
    ST_ALARM = 2'd2
  } beltState_t;

  typedef struct packed {
    logic clr;
    logic inc;
  } cntCmd_t;

endpackage

// File: rtl/belt_timer.sv
module belt_timer
  import belt_pkg::*;
#(
  parameter int WAIT_SECS  = 10,
  parameter int ALARM_SECS = 5
) (
  input  logic    clk,
  input  logic    rst,
  input  cntCmd_t cmd,
  output logic    waitLast,
  output logic    alarmLast
);

  localparam int MAX_SECS = (WAIT_SECS > ALARM_SECS) ? WAIT_SECS : ALARM_SECS;
  localparam int CNT_W = (MAX_SECS < 2) ? 1 : $clog2(MAX_SECS);
  localparam logic [CNT_W-1:0] WAIT_LAST  = CNT_W'(WAIT_SECS - 1);
  localparam logic [CNT_W-1:0] ALARM_LAST = CNT_W'(ALARM_SECS - 1);
  localparam logic [CNT_W-1:0] CNT_TOP    = CNT_W'(MAX_SECS - 1);

  logic [CNT_W-1:0] secCnt;

  always_ff @(posedge clk) begin
    if (rst || cmd.clr) secCnt <= '0;
    else if (cmd.inc)   secCnt <= secCnt + 1'b1;
  end

  assign waitLast  = (secCnt == WAIT_LAST);
  assign alarmLast = (secCnt == ALARM_LAST);

  // R10: a state entry always starts the count from zero
  assert_count_restart_R10: assert property (@(posedge clk) disable iff (rst)
    cmd.clr |=> (secCnt == '0));

  // R3: the control never lets the count run past the longest interval
  assert_count_bound_R3: assert property (@(posedge clk) disable iff (rst)
    secCnt <= CNT_TOP);

endmodule

// File: rtl/belt_ctrl.sv
module belt_ctrl
  import belt_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       ignOn,
  input  logic       beltOn,
  input  logic       secTick,
  input  logic       waitLast,
  input  logic       alarmLast,
  output cntCmd_t    cmd,
  output beltState_t state
);

  beltState_t nextState;
  logic       ignPrev;
  logic       ignRise;
  logic       cancel;

  assign ignRise = ignOn && !ignPrev;
  assign cancel  = !ignOn || beltOn;

  always_ff @(posedge clk) begin
    if (rst) begin
      state   <= ST_IDLE;
      ignPrev <= 1'b0;
    end else begin
      state   <= nextState;
      ignPrev <= ignOn;
    end
  end

  always_comb begin
    nextState = state;
    unique case (state)
      ST_IDLE:  if (ignRise) nextState = ST_WAIT;
      ST_WAIT: begin
        if (cancel)                    nextState = ST_IDLE;
        else if (secTick && waitLast)  nextState = ST_ALARM;
      end
      ST_ALARM: if (cancel || (secTick && alarmLast)) nextState = ST_IDLE;
      default:  nextState = ST_IDLE;
    endcase
  end

  always_comb begin
    cmd.clr = (nextState != state);
    cmd.inc = secTick && !cmd.clr && (state != ST_IDLE);
  end

  // R6/R7: belt latched or ignition off during the alarm drops it
  assert_alarm_cancel_R6: assert property (@(posedge clk) disable iff (rst)
    (state == ST_ALARM && cancel) |=> (state == ST_IDLE));

  // R4: cancel during the wait returns to idle, never to alarm
  assert_wait_cancel_R4: assert property (@(posedge clk) disable iff (rst)
    (state == ST_WAIT && cancel) |=> (state == ST_IDLE));

  // R8: idle is left only on an ignition rising edge
  assert_no_rearm_R8: assert property (@(posedge clk) disable iff (rst)
    (state == ST_IDLE && !ignRise) |=> (state == ST_IDLE));

  // R2: an ignition rising edge while idle arms the wait
  assert_arm_R2: assert property (@(posedge clk) disable iff (rst)
    (state == ST_IDLE && ignRise) |=> (state == ST_WAIT));

  // R3: the alarm is entered only from the waiting state
  assert_alarm_entry_R3: assert property (@(posedge clk) disable iff (rst)
    (state == ST_ALARM && $past(state) != ST_ALARM) |-> ($past(state) == ST_WAIT));

endmodule

// File: rtl/belt_alarm_ctrl.sv
module belt_alarm_ctrl
  import belt_pkg::*;
#(
  parameter int WAIT_SECS  = 10,
  parameter int ALARM_SECS = 5
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       ignOn,
  input  logic       beltOn,
  input  logic       secTick,
  output logic       alarmOut,
  output logic [1:0] stateOut
);

  cntCmd_t    cmd;
  beltState_t state;
  logic       waitLast;
  logic       alarmLast;

  belt_ctrl u_ctrl (
    .clk       (clk),
    .rst       (rst),
    .ignOn     (ignOn),
    .beltOn    (beltOn),
    .secTick   (secTick),
    .waitLast  (waitLast),
    .alarmLast (alarmLast),
    .cmd       (cmd),
    .state     (state)
  );

  belt_timer #(
    .WAIT_SECS  (WAIT_SECS),
    .ALARM_SECS (ALARM_SECS)
  ) u_timer (
    .clk       (clk),
    .rst       (rst),
    .cmd       (cmd),
    .waitLast  (waitLast),
    .alarmLast (alarmLast)
  );

  assign alarmOut = (state == ST_ALARM);
  assign stateOut = state;

  // R1: reset leaves the alarm low on the following cycle
  assert_reset_quiet_R1: assert property (@(posedge clk)
    rst |=> !alarmOut);

endmodule

// File: tb/test_belt_alarm_ctrl.sv
`timescale 1ns/1ps
module test_belt_alarm_ctrl;

  localparam int WAIT_SECS  = 10;
  localparam int ALARM_SECS = 5;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       ignOn = 1'b0;
  logic       beltOn = 1'b0;
  logic       secTick = 1'b0;
  logic       alarmOut;
  logic [1:0] stateOut;

  int errors = 0;
  int checks = 0;

  // reference model
  int  mState = 0;
  int  mCnt = 0;
  bit  mIgnPrev = 0;

  always #5 clk = ~clk;

  belt_alarm_ctrl #(.WAIT_SECS(WAIT_SECS), .ALARM_SECS(ALARM_SECS)) i_belt_alarm_ctrl (
    .clk(clk), .rst(rst), .ignOn(ignOn), .beltOn(beltOn), .secTick(secTick),
    .alarmOut(alarmOut), .stateOut(stateOut)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  function automatic string tagOf(input int st);
    if (st == 0) return "R2";
    if (st == 1) return "R3";
    return "R5";
  endfunction

  function automatic int modelNext(input int st, input int cnt, input bit ign,
                                   input bit belt, input bit tick, input bit prev);
    bit cancel = !ign || belt;
    if (st == 0) return (ign && !prev) ? 1 : 0;
    if (st == 1) return cancel ? 0 : ((tick && cnt == WAIT_SECS - 1) ? 2 : 1);
    return (cancel || (tick && cnt == ALARM_SECS - 1)) ? 0 : 2;
  endfunction

  task automatic step(input bit ign, input bit belt, input bit tick);
    int nxt;
    string tag;
    @(negedge clk);
    ignOn = ign; beltOn = belt; secTick = tick;
    @(posedge clk);
    tag = tagOf(mState);
    if (rst) begin
      mState = 0; mCnt = 0; mIgnPrev = 0;
    end else begin
      nxt = modelNext(mState, mCnt, ign, belt, tick, mIgnPrev);
      if (nxt != mState) mCnt = 0;
      else if (tick && mState != 0) mCnt++;
      mState = nxt;
      mIgnPrev = ign;
    end
    #1;
    chk(tag, int'(stateOut), mState);
    chk(tag, int'(alarmOut), (mState == 2) ? 1 : 0);
  endtask

  task automatic ticks(input int n, input bit ign, input bit belt);
    for (int i = 0; i < n; i++) begin
      step(ign, belt, 1'b1);
      step(ign, belt, 1'b0);
    end
  endtask

  task automatic goIdle();
    step(1'b0, 1'b0, 1'b0);
    step(1'b0, 1'b0, 1'b0);
  endtask

  initial begin
    #(200000 * 10);
    errors++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    void'($urandom(32'h5EA7B17));
    step(1'b0, 1'b0, 1'b0);
    step(1'b0, 1'b0, 1'b0);
    rst = 1'b0;
    chk("R1", int'(stateOut), 0);
    chk("R1", int'(alarmOut), 0);

    // R10: ticks while idle must not shorten the wait
    ticks(20, 1'b0, 1'b0);
    step(1'b1, 1'b0, 1'b0);
    chk("R2", int'(stateOut), 1);
    ticks(WAIT_SECS - 1, 1'b1, 1'b0);
    chk("R10", int'(stateOut), 1);
    step(1'b1, 1'b0, 1'b1);
    chk("R3", int'(stateOut), 2);
    chk("R3", int'(alarmOut), 1);
    ticks(ALARM_SECS - 1, 1'b1, 1'b0);
    chk("R5", int'(alarmOut), 1);
    step(1'b1, 1'b0, 1'b1);
    chk("R5", int'(alarmOut), 0);
    chk("R5", int'(stateOut), 0);
    ticks(15, 1'b1, 1'b0);
    chk("R8", int'(stateOut), 0);
    goIdle();
    step(1'b1, 1'b0, 1'b0);
    chk("R8", int'(stateOut), 1);

    // R4: belt fastened during wait
    ticks(3, 1'b1, 1'b0);
    step(1'b1, 1'b1, 1'b0);
    chk("R4", int'(stateOut), 0);
    chk("R4", int'(alarmOut), 0);
    ticks(12, 1'b1, 1'b0);
    chk("R8", int'(stateOut), 0);
    goIdle();
    step(1'b1, 1'b0, 1'b0);
    ticks(WAIT_SECS - 1, 1'b1, 1'b0);
    chk("R10", int'(stateOut), 1);
    // R4: ignition off during wait
    step(1'b0, 1'b0, 1'b0);
    chk("R4", int'(stateOut), 0);
    chk("R4", int'(alarmOut), 0);

    // R6: belt during alarm
    step(1'b1, 1'b0, 1'b0);
    ticks(WAIT_SECS, 1'b1, 1'b0);
    chk("R3", int'(alarmOut), 1);
    ticks(2, 1'b1, 1'b0);
    step(1'b1, 1'b1, 1'b0);
    chk("R6", int'(alarmOut), 0);
    chk("R6", int'(stateOut), 0);

    // R7: ignition off during alarm
    goIdle();
    step(1'b1, 1'b0, 1'b0);
    ticks(WAIT_SECS, 1'b1, 1'b0);
    step(1'b0, 1'b0, 1'b0);
    chk("R7", int'(alarmOut), 0);
    chk("R7", int'(stateOut), 0);

    // R9: cancel coincident with expiring tick
    step(1'b1, 1'b0, 1'b0);
    ticks(WAIT_SECS - 1, 1'b1, 1'b0);
    step(1'b1, 1'b1, 1'b1);
    chk("R9", int'(stateOut), 0);
    chk("R9", int'(alarmOut), 0);
    goIdle();
    step(1'b1, 1'b0, 1'b0);
    ticks(WAIT_SECS, 1'b1, 1'b0);
    ticks(ALARM_SECS - 1, 1'b1, 1'b0);
    step(1'b0, 1'b0, 1'b1);
    chk("R9", int'(stateOut), 0);

    // random traffic against the model
    for (int i = 0; i < 6000; i++) begin
      bit ign = ((($urandom % 40) == 0) ? !ignOn : ignOn);
      bit belt = ((($urandom % 30) == 0) ? !beltOn : beltOn);
      bit tk = (($urandom % 3) == 0);
      if (($urandom % 400) == 0) begin
        rst = 1'b1;
        step(ign, belt, tk);
        rst = 1'b0;
        chk("R1", int'(stateOut), 0);
      end else begin
        step(ign, belt, tk);
      end
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule